// File: doc/BRIEF.md
# Serial Synthesizer Latch and Counter Readout Port

This block is a small bus peripheral for a frequency-synthesizer controller. Software loads two wide latches without a wide data path. Each write to the command register can push one data bit into a 24-bit shift register, most significant bit first. Separate transfer bits in the same register then copy the assembled word into either the divide-ratio (N) latch or the control latch. Both latches drive the synthesizer directly.

The same command register also clears a 19-bit event counter and rewinds a byte selector. The counter counts event strobes while a gate input is open, and it raises a valid flag when a gate-done pulse arrives. A single read address returns three bytes in turn. The first byte carries the phase detector's status flags and the counter's top three bits. The second byte carries counter bits 15 to 8, and the third carries bits 7 to 0. The count is frozen when the first byte is read, so all three bytes describe the same value. The phase detector is outside the block, and its flags arrive as plain inputs.

Top module: `pll_serial_port`

## Requirements
- R1: A write with bit 7 set shifts the 24-bit shift register left by one. Write bit 0 enters at the least significant end, so a word is loaded most significant bit first.
- R2: A write with bit 1 set copies the shift register to `n_word`. `n_word` changes at no other time.
- R3: A write with bit 4 set copies the shift register to `ctl_word`. `ctl_word` changes at no other time.
- R4: When one write sets bit 7 together with bit 1 or bit 4, the latch receives the value that already includes the new bit.
- R5: Write bits 6 and 2 have no effect. They change neither latch, the shift register, the counter nor the selector.
- R6: The counter increments once per clock in which `evt_strobe` and `gate_open` are both high. Strobes while the gate is closed are not counted.
- R7: A `gate_done` pulse sets the valid flag, which then stays set until a clear.
- R8: A write with bit 5 set clears both the counter and the valid flag. This takes priority over an event or a `gate_done` pulse in the same cycle.
- R9: The first byte read is {err_low, err_high, 1, locked, valid, count[18:16]}, from bit 7 down to bit 0.
- R10: Reads advance the selector from the first byte to the middle byte (count[15:8]) and then to the low byte (count[7:0]). The selector stays at the low byte on further reads.
- R11: The count is captured when the first byte is read, and the middle and low bytes come from that capture.
- R12: A write with bit 3 set returns the selector to the first byte. This takes priority over a read in the same cycle.
- R13: After reset, both latches, the shift register, the counter and the valid flag are zero, the selector points at the first byte, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 8 | Command byte |
| rd_en | input | 1 | Readout port read strobe |
| rd_data | output | 8 | Byte returned by the latest read, valid the cycle after `rd_en` |
| evt_strobe | input | 1 | Event to be counted |
| gate_open | input | 1 | Counting window open |
| gate_done | input | 1 | Count-complete pulse, sets the valid flag |
| err_low | input | 1 | Phase error below the lower threshold |
| err_high | input | 1 | Phase error above the upper threshold |
| locked | input | 1 | Phase lock indication |
| n_word | output | 24 | Divide-ratio latch |
| ctl_word | output | 24 | Control latch |

## Verification
The serial path is tested with four 24-bit words: alternating bits, all ones, a single set bit at each end, and an irregular value. These show whether the bit order is reversed, whether a bit is dropped, and whether a word went to the wrong latch. The counter is driven past 65,536 events so that the top three bits are non-zero. Extra events after the first byte is read show whether the capture really froze the value. Single-cycle collisions (clear with an event and a done pulse, selector rewind with a read, shift with a transfer) test the priority order. A write with only bits 6 and 2 set is followed by a read and a transfer, to show that nothing moved.

// File: rtl/pll_port_pkg.sv
package pll_port_pkg;

    typedef enum logic [1:0] {
        SEL_HEAD = 2'd0,
        SEL_MID  = 2'd1,
        SEL_LOW  = 2'd2
    } sel_e;

    typedef struct packed {
        logic shift;
        logic bit_in;
        logic load_n;
        logic load_ctl;
        logic clr_cnt;
        logic rst_sel;
    } wr_cmd_t;

    localparam int CMD_SHIFT = 7;
    localparam int CMD_CLR   = 5;
    localparam int CMD_LCTL  = 4;
    localparam int CMD_RSEL  = 3;
    localparam int CMD_LN    = 1;
    localparam int CMD_DATA  = 0;

endpackage

// File: rtl/pll_serial_latches.sv
module pll_serial_latches
    import pll_port_pkg::*;
#(
    parameter int SHIFT_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wr_cmd_t            cmd,
    output logic [SHIFT_W-1:0] n_word,
    output logic [SHIFT_W-1:0] ctl_word
);

    typedef struct packed {
        logic [SHIFT_W-1:0] sh;
        logic [SHIFT_W-1:0] n;
        logic [SHIFT_W-1:0] ctl;
    } lat_st_t;

    lat_st_t            st_d, st_q;
    logic [SHIFT_W-1:0] shifted;

    always_comb begin
        st_d    = st_q;
        shifted = cmd.shift ? {st_q.sh[SHIFT_W-2:0], cmd.bit_in} : st_q.sh;
        st_d.sh = shifted;
        if (cmd.load_n)   st_d.n   = shifted;
        if (cmd.load_ctl) st_d.ctl = shifted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign n_word   = st_q.n;
    assign ctl_word = st_q.ctl;

endmodule

// File: rtl/pll_event_counter.sv
module pll_event_counter #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt,
    input  logic             gate_open,
    input  logic             gate_done,
    output logic [CNT_W-1:0] count,
    output logic             valid
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             valid;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt   = '0;
            st_d.valid = 1'b0;
        end else begin
            if (evt && gate_open) st_d.cnt = st_q.cnt + CNT_W'(1);
            if (gate_done)        st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign valid = st_q.valid;

endmodule

// File: rtl/pll_readout_seq.sv
module pll_readout_seq
    import pll_port_pkg::*;
#(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             rst_sel,
    input  logic [CNT_W-1:0] count,
    input  logic             valid,
    input  logic             err_low,
    input  logic             err_high,
    input  logic             locked,
    output logic [7:0]       rd_data,
    output logic [1:0]       sel
);

    localparam int WIDE_W = 24;

    typedef struct packed {
        sel_e             sel;
        logic [CNT_W-1:0] snap;
        logic [7:0]       rd;
    } seq_st_t;

    seq_st_t           st_d, st_q;
    logic [WIDE_W-1:0] live_w, snap_w;
    logic [7:0]        head;

    always_comb begin
        live_w = WIDE_W'(count);
        snap_w = WIDE_W'(st_q.snap);
        head   = {err_low, err_high, 1'b1, locked, valid, live_w[18:16]};
        st_d   = st_q;
        if (rd_en) begin
            unique case (st_q.sel)
                SEL_HEAD: begin
                    st_d.rd   = head;
                    st_d.snap = count;
                    st_d.sel  = SEL_MID;
                end
                SEL_MID: begin
                    st_d.rd  = snap_w[15:8];
                    st_d.sel = SEL_LOW;
                end
                default: begin
                    st_d.rd  = snap_w[7:0];
                    st_d.sel = SEL_LOW;
                end
            endcase
        end
        if (rst_sel) st_d.sel = SEL_HEAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sel: SEL_HEAD, snap: '0, rd: '0};
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd;
    assign sel     = st_q.sel;

endmodule

// File: rtl/pll_serial_port.sv
module pll_serial_port
    import pll_port_pkg::*;
#(
    parameter int SHIFT_W = 24,
    parameter int CNT_W   = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               rd_en,
    output logic [7:0]         rd_data,
    input  logic               evt_strobe,
    input  logic               gate_open,
    input  logic               gate_done,
    input  logic               err_low,
    input  logic               err_high,
    input  logic               locked,
    output logic [SHIFT_W-1:0] n_word,
    output logic [SHIFT_W-1:0] ctl_word
);

    wr_cmd_t          cmd;
    logic [CNT_W-1:0] cnt_w;
    logic             valid_w;
    logic [1:0]       sel_w;

    always_comb begin
        cmd.shift    = wr_en & wr_data[CMD_SHIFT];
        cmd.bit_in   = wr_data[CMD_DATA];
        cmd.load_n   = wr_en & wr_data[CMD_LN];
        cmd.load_ctl = wr_en & wr_data[CMD_LCTL];
        cmd.clr_cnt  = wr_en & wr_data[CMD_CLR];
        cmd.rst_sel  = wr_en & wr_data[CMD_RSEL];
    end

    pll_serial_latches #(.SHIFT_W(SHIFT_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .n_word   (n_word),
        .ctl_word (ctl_word)
    );

    pll_event_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cmd.clr_cnt),
        .evt       (evt_strobe),
        .gate_open (gate_open),
        .gate_done (gate_done),
        .count     (cnt_w),
        .valid     (valid_w)
    );

    pll_readout_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rst_sel  (cmd.rst_sel),
        .count    (cnt_w),
        .valid    (valid_w),
        .err_low  (err_low),
        .err_high (err_high),
        .locked   (locked),
        .rd_data  (rd_data),
        .sel      (sel_w)
    );

endmodule

// File: rtl/pll_serial_port_chk.sv
module pll_serial_port_chk #(
    parameter int SHIFT_W = 24,
    parameter int CNT_W   = 19
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [7:0]         wr_data,
    input logic               rd_en,
    input logic [7:0]         rd_data,
    input logic               evt_strobe,
    input logic               gate_open,
    input logic               gate_done,
    input logic [SHIFT_W-1:0] n_word,
    input logic [SHIFT_W-1:0] ctl_word,
    input logic [CNT_W-1:0]   cnt,
    input logic               valid,
    input logic [1:0]         sel
);

    logic clr, rsel;
    assign clr  = wr_en && wr_data[5];
    assign rsel = wr_en && wr_data[3];

    assert_n_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[1]) |=> $stable(n_word));

    assert_ctl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[4]) |=> $stable(ctl_word));

    assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(evt_strobe && gate_open)) |=> $stable(cnt));

    assert_valid_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_done && !clr) |=> valid);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !valid));

    assert_head_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == 2'd0) |=> rd_data[5]);

    assert_sel_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rsel && sel != 2'd2) |=> sel == $past(sel) + 2'd1);

    assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rsel && sel == 2'd2) |=> sel == 2'd2);

    assert_sel_rewind_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsel |=> sel == 2'd0);

endmodule

bind pll_serial_port pll_serial_port_chk #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .evt_strobe (evt_strobe),
    .gate_open  (gate_open),
    .gate_done  (gate_done),
    .n_word     (n_word),
    .ctl_word   (ctl_word),
    .cnt        (cnt_w),
    .valid      (valid_w),
    .sel        (sel_w)
);

// File: tb/sim_pll_serial_port.sv
`timescale 1ns/1ps
module sim_pll_serial_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        evt_strobe = 1'b0;
    logic        gate_open = 1'b0;
    logic        gate_done = 1'b0;
    logic        err_low = 1'b0;
    logic        err_high = 1'b0;
    logic        locked = 1'b0;
    logic [23:0] n_word, ctl_word;

    int total = 0;
    int bad   = 0;

    logic [23:0] sh_m  = '0;
    logic [23:0] n_m   = '0;
    logic [23:0] ctl_m = '0;
    logic [7:0]  got;

    always #5 clk = ~clk;

    pll_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .evt_strobe(evt_strobe),
        .gate_open(gate_open), .gate_done(gate_done), .err_low(err_low),
        .err_high(err_high), .locked(locked), .n_word(n_word), .ctl_word(ctl_word)
    );

    // bit 24: 1 = transfer to N latch, 0 = to control latch; bits 23:0 = word
    localparam logic [24:0] VEC [4] = '{
        {1'b1, 24'hAAAA55},
        {1'b0, 24'hFFFFFF},
        {1'b1, 24'h800001},
        {1'b0, 24'h3C91E7}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic events(input int n);
        @(negedge clk);
        evt_strobe = 1'b1; gate_open = 1'b1;
        repeat (n) @(negedge clk);
        evt_strobe = 1'b0; gate_open = 1'b0;
    endtask

    initial begin
        #1_500_000;
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check("R13 n_word", {8'h0, n_word}, 32'h0);
        check("R13 ctl_word", {8'h0, ctl_word}, 32'h0);
        check("R13 rd_data", {24'h0, rd_data}, 32'h0);
        rd(got); check("R13/R9 head", {24'h0, got}, 32'h20);
        rd(got); check("R13 mid", {24'h0, got}, 32'h00);
        rd(got); check("R13 low", {24'h0, got}, 32'h00);

        // R1 R2 R3 table walk
        for (int v = 0; v < 4; v++) begin
            for (int b = 23; b >= 0; b--) begin
                wr(8'h80 | {7'h0, VEC[v][b]});
                sh_m = {sh_m[22:0], VEC[v][b]};
            end
            if (VEC[v][24]) begin
                wr(8'h02); n_m = sh_m;
            end else begin
                wr(8'h10); ctl_m = sh_m;
            end
            check("R1/R2 n_word", {8'h0, n_word}, {8'h0, n_m});
            check("R1/R3 ctl_word", {8'h0, ctl_word}, {8'h0, ctl_m});
        end

        // R4 shift before transfer in one write
        wr(8'h83); sh_m = {sh_m[22:0], 1'b1}; n_m = sh_m;
        check("R4 n_word", {8'h0, n_word}, {8'h0, n_m});
        wr(8'h90); sh_m = {sh_m[22:0], 1'b0}; ctl_m = sh_m;
        check("R4 ctl_word", {8'h0, ctl_word}, {8'h0, ctl_m});

        // R6 counting: gate closed strobes ignored, then 65541 counted
        @(negedge clk); evt_strobe = 1'b1;
        repeat (50) @(negedge clk);
        evt_strobe = 1'b0;
        events(65541);
        @(negedge clk); gate_done = 1'b1;
        @(negedge clk); gate_done = 1'b0;
        err_low = 1'b1; locked = 1'b1;
        wr(8'h08);
        rd(got); check("R9/R7 head", {24'h0, got}, 32'hB9);
        events(5);
        rd(got); check("R11/R6 mid", {24'h0, got}, 32'h00);
        rd(got); check("R11/R6 low", {24'h0, got}, 32'h05);
        rd(got); check("R10 hold low", {24'h0, got}, 32'h05);

        // R12 rewind, fresh capture
        err_low = 1'b0; err_high = 1'b1; locked = 1'b0;
        wr(8'h08);
        rd(got); check("R12/R9 head", {24'h0, got}, 32'h69);
        rd(got); check("R10 mid", {24'h0, got}, 32'h00);
        rd(got); check("R10 low", {24'h0, got}, 32'h0A);

        // R8 clear wins over event and done in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h28;
        evt_strobe = 1'b1; gate_open = 1'b1; gate_done = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
        evt_strobe = 1'b0; gate_open = 1'b0; gate_done = 1'b0;
        rd(got); check("R8 head", {24'h0, got}, 32'h60);

        // R12 rewind beats a read in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h08; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b0;
        check("R12 concurrent read byte", {24'h0, rd_data}, 32'h00);
        rd(got); check("R12 head after rewind", {24'h0, got}, 32'h60);

        // R5 bits 6 and 2 have no effect (selector now at middle byte)
        wr(8'h44);
        check("R5 n_word", {8'h0, n_word}, {8'h0, n_m});
        check("R5 ctl_word", {8'h0, ctl_word}, {8'h0, ctl_m});
        rd(got); check("R5 selector", {24'h0, got}, 32'h00);
        rd(got); check("R5 counter", {24'h0, got}, 32'h00);
        wr(8'h10); ctl_m = sh_m;
        check("R5 shift reg", {8'h0, ctl_word}, {8'h0, ctl_m});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule